// File: doc/BRIEF.md
# Synchronous Burst Read Address Sequencer

This block sits between a clocked host bus and a 32-bit-wide memory array. When the host pulls chip enable and the load strobe low on a rising clock edge, it captures a start address. With the write/read select high, that address starts a read burst. With the select low, the address is kept as a write address for the program path. A read burst presents four array word addresses one after another. The order is either wrap, where only the lowest two address bits cycle, or linear, where the whole 18-bit address counts up. The block waits a configurable first-word latency before the first word and a configurable per-word latency between words. An advance input can freeze the burst on the current word.

Two registered mode bits are held inside the block. Wrap/linear ordering resets to a parameter default, and synchronous reads are off after reset. Each bit flips on a one-cycle toggle pulse from the command decoder. The output-enable and output-disable inputs are sampled on the clock and produce a registered tri-state drive enable. A data-valid flag marks the cycles when the addressed word is being driven. The array itself is external.

Top module: `burst_rd_seq`

## Requirements
- R1: A read load happens on a rising edge where ce_n=0, ld_n=0, wr_rd=1 and sync_mode=1. It captures addr_in as the burst base, and word_vld is 0 after that edge.
- R2: A write load happens on a rising edge where ce_n=0, ld_n=0 and wr_rd=0. It copies addr_in to waddr and raises waddr_stb for exactly one cycle. It does not start a read burst.
- R3: After a load, changes on addr_in have no effect on arr_addr until the next load.
- R4: With wrap_mode=1, word j (j=0..3) of a burst has address bits [17:2] equal to the base and bits [1:0] equal to (base[1:0]+j) mod 4. After the fourth word, word_vld drops to 0 and no further word follows.
- R5: With wrap_mode=0, word j has address (base+j) mod 2^18, with carries across the four-word boundary and through every higher bit.
- R6: The first word is valid L1 rising edges after the load edge, with L1=3 when cfg_first_long=0 and L1=4 when cfg_first_long=1. Each later word appears L2 edges after the previous one, with L2=1 when cfg_next_long=0 and L2=2 when cfg_next_long=1. Both settings are captured at the load edge.
- R7: A rising edge with adv_n=1 while a word is valid holds that word: word_vld stays 1 and arr_addr is unchanged.
- R8: dq_oe is registered. It is 1 after an edge where sync mode is on, ce_n=0, oe_n=0 and od_n=1, and it is 0 after an edge where oe_n=1. data_vld is 1 only when dq_oe=1 and word_vld=1.
- R9: An edge with od_n=0 forces dq_oe to 0 after that edge, whatever the value of oe_n.
- R10: After reset, wrap_mode equals the WRAP_DEFAULT parameter (1) and sync_mode is 0. A one-cycle tog_wrap or tog_sync pulse flips the matching mode bit. While sync_mode is 0, a load starts no burst.
- R11: A rising edge with rst_n=0 leaves dq_oe=0, word_vld=0, data_vld=0, sync_mode=0 and wrap_mode=WRAP_DEFAULT.
- R12: A read load during a running burst cancels that burst. A new burst then starts from the newly captured address with full first-word latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| ld_n | input | 1 | Load-address strobe, active low |
| wr_rd | input | 1 | Load type: 1 = read address, 0 = write address |
| adv_n | input | 1 | Burst advance, active low; high suspends |
| oe_n | input | 1 | Output enable, active low, sampled on clock |
| od_n | input | 1 | Output disable, active low, overrides oe_n |
| addr_in | input | AW | Host address |
| tog_wrap | input | 1 | One-cycle pulse flipping wrap/linear order |
| tog_sync | input | 1 | One-cycle pulse flipping synchronous read mode |
| cfg_first_long | input | 1 | First-word latency select (0: 3, 1: 4) |
| cfg_next_long | input | 1 | Next-word latency select (0: 1, 1: 2) |
| arr_addr | output | AW | Current burst word address to the array |
| word_vld | output | 1 | A burst word is being presented |
| data_vld | output | 1 | Word is presented and outputs are driven |
| dq_oe | output | 1 | Registered tri-state drive enable for the data bus |
| waddr | output | AW | Captured write address |
| waddr_stb | output | 1 | One-cycle pulse after a write load |
| sync_mode | output | 1 | Synchronous read mode bit |
| wrap_mode | output | 1 | 1 = wrap order, 0 = linear order |

## Verification
The bench uses the default parameters: an 18-bit address, a four-word burst, first-word latencies of 3 and 4, next-word latencies of 1 and 2, and wrap as the reset order. All four latency combinations are reachable through the configuration inputs, so every burst is checked cycle by cycle against a timing model built from the two selected latencies. An 18-bit address makes the linear carry at the top of the address space reachable: a base near the maximum value rolls over to zero. Wrap is checked with a base that is not aligned, so the low two bits roll over inside the group.

// File: rtl/brs_pkg.sv
// Package brs_pkg
// Shared helpers for the burst read sequencer. Holds the latency
// selection function used when a burst is loaded.
package brs_pkg;

    // Returns the long or short latency value based on a select bit.
    function automatic int unsigned lat_pick(input logic sel,
                                             input int unsigned short_v,
                                             input int unsigned long_v);
        return sel ? long_v : short_v;
    endfunction

endpackage

// File: rtl/brs_mode_regs.sv
// Module brs_mode_regs
// Holds the wrap/linear order bit and the synchronous read enable bit.
// Each bit flips on a one-cycle toggle pulse. The next value of the sync
// bit is also output, so downstream logic can act on it in the same cycle.
// Assumes toggle pulses come from an upstream command decoder.
module brs_mode_regs #(
    parameter bit WRAP_DEFAULT = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tog_wrap,
    input  logic tog_sync,
    output logic sync_mode,
    output logic sync_nxt,
    output logic wrap_mode
);

    // Next value of the sync bit after a possible toggle.
    always_comb sync_nxt = sync_mode ^ tog_sync;

    // Mode bit registers with reset defaults.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_mode <= 1'b0;
            wrap_mode <= WRAP_DEFAULT;
        end else begin
            sync_mode <= sync_nxt;
            wrap_mode <= wrap_mode ^ tog_wrap;
        end
    end

endmodule

// File: rtl/brs_addr_latch.sv
// Module brs_addr_latch
// Captures the burst base address on a read load, and the write address
// on a write load. A strobe pulses for one cycle after a write load.
// Assumes the load qualifiers are decoded by the parent.
module brs_addr_latch #(
    parameter int AW = 18
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_load,
    input  logic          wr_load,
    input  logic [AW-1:0] addr_in,
    output logic [AW-1:0] base,
    output logic [AW-1:0] waddr,
    output logic          waddr_stb
);

    // Burst base register; written only on a read load.
    always_ff @(posedge clk) begin
        if (!rst_n)       base <= '0;
        else if (rd_load) base <= addr_in;
    end

    // Write address register and its one-cycle strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            waddr     <= '0;
            waddr_stb <= 1'b0;
        end else begin
            waddr_stb <= wr_load;
            if (wr_load) waddr <= addr_in;
        end
    end

endmodule

// File: rtl/brs_burst_ctr.sv
// Module brs_burst_ctr
// Controls the burst. It counts the first-word latency, then presents
// BURST_LEN words, spaced by the next-word latency, and ends after the
// last word. adv_n high holds the current word. A read load restarts
// the burst. Clearing sync mode cancels it. Both latency selects are
// captured at the load edge.
module brs_burst_ctr #(
    parameter int BURST_LEN   = 4,
    parameter int FIRST_SHORT = 3,
    parameter int FIRST_LONG  = 4,
    parameter int NEXT_SHORT  = 1,
    parameter int NEXT_LONG   = 2,
    localparam int IDX_W = $clog2(BURST_LEN),
    localparam int LAT_W = $clog2(FIRST_LONG + NEXT_LONG + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_load,
    input  logic             sync_nxt,
    input  logic             adv_n,
    input  logic             cfg_first_long,
    input  logic             cfg_next_long,
    output logic [IDX_W-1:0] idx,
    output logic             word_vld
);
    import brs_pkg::*;

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(BURST_LEN - 1);

    logic             busy;
    logic             next_long_q;
    logic [LAT_W-1:0] wait_cnt;
    logic [LAT_W-1:0] first_reload;
    logic [LAT_W-1:0] next_reload;

    // Counter reload values; the next-word value comes from the captured select.
    always_comb begin
        first_reload = LAT_W'(lat_pick(cfg_first_long, FIRST_SHORT, FIRST_LONG) - 1);
        next_reload  = LAT_W'(lat_pick(next_long_q, NEXT_SHORT, NEXT_LONG) - 1);
    end

    // Burst state machine: load, first latency, word stepping and end of burst.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy        <= 1'b0;
            word_vld    <= 1'b0;
            idx         <= '0;
            wait_cnt    <= '0;
            next_long_q <= 1'b0;
        end else if (!sync_nxt) begin
            busy     <= 1'b0;
            word_vld <= 1'b0;
        end else if (rd_load) begin
            busy        <= 1'b1;
            word_vld    <= 1'b0;
            idx         <= '0;
            wait_cnt    <= first_reload;
            next_long_q <= cfg_next_long;
        end else if (busy) begin
            if (!word_vld) begin
                if (wait_cnt == '0) begin
                    word_vld <= 1'b1;
                    wait_cnt <= next_reload;
                end else begin
                    wait_cnt <= wait_cnt - 1'b1;
                end
            end else if (!adv_n) begin
                if (wait_cnt != '0) begin
                    wait_cnt <= wait_cnt - 1'b1;
                end else if (idx == LAST_IDX) begin
                    busy     <= 1'b0;
                    word_vld <= 1'b0;
                end else begin
                    idx      <= idx + 1'b1;
                    wait_cnt <= next_reload;
                end
            end
        end
    end

endmodule

// File: rtl/brs_addr_gen.sv
// Module brs_addr_gen
// Builds the array word address from the base and the burst index.
// In wrap order, only the low index-width bits count, modulo the burst
// length. In linear order, the full address adds the index with carry.
// Purely combinational.
module brs_addr_gen #(
    parameter int AW        = 18,
    parameter int BURST_LEN = 4,
    localparam int IDX_W = $clog2(BURST_LEN)
) (
    input  logic [AW-1:0]    base,
    input  logic [IDX_W-1:0] idx,
    input  logic             wrap_mode,
    output logic [AW-1:0]    arr_addr
);

    logic [AW-1:0]    lin_addr;
    logic [IDX_W-1:0] low_wrap;

    // Both orderings are computed; the mode bit picks one.
    always_comb begin
        lin_addr = base + AW'(idx);
        low_wrap = base[IDX_W-1:0] + idx;
    end

    generate
        if (IDX_W < AW) begin : g_split
            // Upper bits stay fixed in wrap order.
            always_comb arr_addr = wrap_mode ? {base[AW-1:IDX_W], low_wrap} : lin_addr;
        end else begin : g_full
            // Index covers the whole address: both orders match modulo 2^AW.
            always_comb arr_addr = wrap_mode ? AW'(low_wrap) : lin_addr;
        end
    endgenerate

endmodule

// File: rtl/brs_out_gate.sv
// Module brs_out_gate
// Registers the data-bus drive enable from the sampled output enable,
// output disable and chip enable. Output disable wins over output enable.
// Drive requires sync mode to be on after this edge.
module brs_out_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic sync_nxt,
    input  logic ce_n,
    input  logic oe_n,
    input  logic od_n,
    output logic dq_oe
);

    // Drive enable register, off in reset.
    always_ff @(posedge clk) begin
        if (!rst_n) dq_oe <= 1'b0;
        else        dq_oe <= sync_nxt & ~ce_n & ~oe_n & od_n;
    end

endmodule

// File: rtl/burst_rd_seq.sv
// Module burst_rd_seq
// Top level of the synchronous burst read address sequencer. It decodes
// read and write loads from the strobes, captures addresses, runs the
// latency and burst counters, builds the word address, and gates the
// data-bus drive. Assumes all inputs are synchronous to clk and that the
// toggle pulses last one cycle.
module burst_rd_seq #(
    parameter int AW           = 18,
    parameter int BURST_LEN    = 4,
    parameter int FIRST_SHORT  = 3,
    parameter int FIRST_LONG   = 4,
    parameter int NEXT_SHORT   = 1,
    parameter int NEXT_LONG    = 2,
    parameter bit WRAP_DEFAULT = 1'b1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ce_n,
    input  logic          ld_n,
    input  logic          wr_rd,
    input  logic          adv_n,
    input  logic          oe_n,
    input  logic          od_n,
    input  logic [AW-1:0] addr_in,
    input  logic          tog_wrap,
    input  logic          tog_sync,
    input  logic          cfg_first_long,
    input  logic          cfg_next_long,
    output logic [AW-1:0] arr_addr,
    output logic          word_vld,
    output logic          data_vld,
    output logic          dq_oe,
    output logic [AW-1:0] waddr,
    output logic          waddr_stb,
    output logic          sync_mode,
    output logic          wrap_mode
);

    localparam int IDX_W = $clog2(BURST_LEN);

    logic             sync_nxt;
    logic             rd_load;
    logic             wr_load;
    logic [AW-1:0]    base;
    logic [IDX_W-1:0] idx;

    // Load decode: the read load needs sync mode; the write load does not.
    always_comb begin
        rd_load = ~ce_n & ~ld_n &  wr_rd & sync_mode;
        wr_load = ~ce_n & ~ld_n & ~wr_rd;
    end

    brs_mode_regs #(.WRAP_DEFAULT(WRAP_DEFAULT)) u_mode (
        .clk       (clk),
        .rst_n     (rst_n),
        .tog_wrap  (tog_wrap),
        .tog_sync  (tog_sync),
        .sync_mode (sync_mode),
        .sync_nxt  (sync_nxt),
        .wrap_mode (wrap_mode)
    );

    brs_addr_latch #(.AW(AW)) u_latch (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_load   (rd_load),
        .wr_load   (wr_load),
        .addr_in   (addr_in),
        .base      (base),
        .waddr     (waddr),
        .waddr_stb (waddr_stb)
    );

    brs_burst_ctr #(
        .BURST_LEN   (BURST_LEN),
        .FIRST_SHORT (FIRST_SHORT),
        .FIRST_LONG  (FIRST_LONG),
        .NEXT_SHORT  (NEXT_SHORT),
        .NEXT_LONG   (NEXT_LONG)
    ) u_ctr (
        .clk            (clk),
        .rst_n          (rst_n),
        .rd_load        (rd_load),
        .sync_nxt       (sync_nxt),
        .adv_n          (adv_n),
        .cfg_first_long (cfg_first_long),
        .cfg_next_long  (cfg_next_long),
        .idx            (idx),
        .word_vld       (word_vld)
    );

    brs_addr_gen #(.AW(AW), .BURST_LEN(BURST_LEN)) u_agen (
        .base      (base),
        .idx       (idx),
        .wrap_mode (wrap_mode),
        .arr_addr  (arr_addr)
    );

    brs_out_gate u_gate (
        .clk      (clk),
        .rst_n    (rst_n),
        .sync_nxt (sync_nxt),
        .ce_n     (ce_n),
        .oe_n     (oe_n),
        .od_n     (od_n),
        .dq_oe    (dq_oe)
    );

    // Valid data only while a word is presented and the bus is driven.
    always_comb data_vld = dq_oe & word_vld;

endmodule

// File: rtl/burst_rd_seq_chk.sv
// Module burst_rd_seq_chk
// Port-level checker for burst_rd_seq, attached with bind below.
module burst_rd_seq_chk #(
    parameter int AW           = 18,
    parameter int BURST_LEN    = 4,
    parameter bit WRAP_DEFAULT = 1'b1,
    localparam int IW = $clog2(BURST_LEN)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ce_n,
    input logic          ld_n,
    input logic          wr_rd,
    input logic          adv_n,
    input logic          oe_n,
    input logic          od_n,
    input logic [AW-1:0] addr_in,
    input logic          tog_wrap,
    input logic          tog_sync,
    input logic [AW-1:0] arr_addr,
    input logic          word_vld,
    input logic          dq_oe,
    input logic [AW-1:0] waddr,
    input logic          waddr_stb,
    input logic          sync_mode,
    input logic          wrap_mode
);

    logic rd_ld, wr_ld;
    logic rst_seen = 1'b0;

    // Load conditions seen at the ports.
    always_comb begin
        rd_ld = !ce_n && !ld_n && wr_rd && sync_mode;
        wr_ld = !ce_n && !ld_n && !wr_rd;
    end

    // R1: a read load clears the presented word.
    a_r1_load_clears: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ld |=> !word_vld);

    // R2: a write load shows the address with a strobe.
    a_r2_wr_latch: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ld |=> (waddr_stb && waddr == $past(addr_in)));

    // R4: in wrap order the upper address bits do not move within a burst.
    a_r4_wrap_upper: assert property (@(posedge clk) disable iff (!rst_n)
        (word_vld && wrap_mode && !tog_wrap && !rd_ld && !tog_sync)
        |=> (!word_vld || arr_addr[AW-1:IW] == $past(arr_addr[AW-1:IW])));

    // R7: a suspended advance holds the word.
    a_r7_suspend_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (word_vld && adv_n && !rd_ld && !tog_sync && !tog_wrap)
        |=> (word_vld && $stable(arr_addr)));

    // R8: output enable high turns the drive off.
    a_r8_oe_off: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |=> !dq_oe);

    // R9: output disable overrides output enable.
    a_r9_od_override: assert property (@(posedge clk) disable iff (!rst_n)
        !od_n |=> !dq_oe);

    // R10: no burst word is shown outside sync mode.
    a_r10_vld_needs_sync: assert property (@(posedge clk) disable iff (!rst_n)
        word_vld |-> sync_mode);

    // R11: after a reset edge, the outputs and modes are in their reset state.
    always_ff @(posedge clk) rst_seen <= !rst_n;
    always @(negedge clk) begin
        if (rst_seen) begin
            a_r11_reset_state: assert (!dq_oe && !word_vld && !sync_mode
                                       && wrap_mode == WRAP_DEFAULT);
        end
    end

endmodule

bind burst_rd_seq burst_rd_seq_chk #(
    .AW(AW), .BURST_LEN(BURST_LEN), .WRAP_DEFAULT(WRAP_DEFAULT)
) u_chk (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .ld_n(ld_n), .wr_rd(wr_rd),
    .adv_n(adv_n), .oe_n(oe_n), .od_n(od_n), .addr_in(addr_in),
    .tog_wrap(tog_wrap), .tog_sync(tog_sync), .arr_addr(arr_addr),
    .word_vld(word_vld), .dq_oe(dq_oe), .waddr(waddr), .waddr_stb(waddr_stb),
    .sync_mode(sync_mode), .wrap_mode(wrap_mode)
);

// File: tb/tb_burst_rd_seq.sv
// Directed bench for burst_rd_seq. Inputs change at the falling edge;
// outputs are sampled at the falling edge after each rising edge.
module tb_burst_rd_seq;

    localparam int AW = 18;

    logic          clk = 1'b0;
    logic          rst_n, ce_n, ld_n, wr_rd, adv_n, oe_n, od_n;
    logic [AW-1:0] addr_in;
    logic          tog_wrap, tog_sync, cfg_first_long, cfg_next_long;
    logic [AW-1:0] arr_addr, waddr;
    logic          word_vld, data_vld, dq_oe, waddr_stb, sync_mode, wrap_mode;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    burst_rd_seq dut (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .ld_n(ld_n), .wr_rd(wr_rd),
        .adv_n(adv_n), .oe_n(oe_n), .od_n(od_n), .addr_in(addr_in),
        .tog_wrap(tog_wrap), .tog_sync(tog_sync),
        .cfg_first_long(cfg_first_long), .cfg_next_long(cfg_next_long),
        .arr_addr(arr_addr), .word_vld(word_vld), .data_vld(data_vld),
        .dq_oe(dq_oe), .waddr(waddr), .waddr_stb(waddr_stb),
        .sync_mode(sync_mode), .wrap_mode(wrap_mode)
    );

    task automatic chk(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    // Word address expected from the requirement text.
    function automatic logic [AW-1:0] exp_addr(input logic [AW-1:0] b,
                                               input bit w, input int j);
        return w ? {b[AW-1:2], 2'(b[1:0] + 2'(j))} : b + AW'(j);
    endfunction

    // Check the cycle n edges after the load edge (R4, R5, R6).
    task automatic check_at(input logic [AW-1:0] b, input bit w,
                            input int l1, input int l2, input int n, input string tag);
        int j;
        if (n < l1) begin
            chk(!data_vld, {tag, " R6 latency"}, 32'(data_vld), 0);
        end else begin
            j = (n - l1) / l2;
            if (j < 4)
                chk(data_vld && arr_addr == exp_addr(b, w, j), tag,
                    {data_vld, 13'd0, arr_addr}, {1'b1, 13'd0, exp_addr(b, w, j)});
            else
                chk(!data_vld, {tag, " R4 end of burst"}, 32'(data_vld), 0);
        end
    endtask

    // Issue a load at the next edge, then scramble addr_in (R3).
    task automatic do_load(input logic [AW-1:0] a, input bit is_read);
        ld_n    = 1'b0;
        wr_rd   = is_read;
        addr_in = a;
        step();
        ld_n    = 1'b1;
        wr_rd   = 1'b1;
        addr_in = ~a;
    endtask

    task automatic run_burst(input logic [AW-1:0] b, input bit w,
                             input bit fl, input bit nl, input string tag);
        int l1 = fl ? 4 : 3;
        int l2 = nl ? 2 : 1;
        cfg_first_long = fl;
        cfg_next_long  = nl;
        do_load(b, 1'b1);
        chk(!word_vld, "R1 word_vld low after load", 32'(word_vld), 0);
        for (int n = 0; n < l1 + 4 * l2 + 2; n++) begin
            check_at(b, w, l1, l2, n, tag);
            addr_in = addr_in ^ 18'h15A5A;
            step();
        end
    endtask

    task automatic pulse_sync();
        tog_sync = 1'b1; step(); tog_sync = 1'b0;
    endtask

    task automatic pulse_wrap();
        tog_wrap = 1'b1; step(); tog_wrap = 1'b0;
    endtask

    task automatic t_reset_state();
        chk(!dq_oe && !data_vld && !sync_mode && wrap_mode,
            "R11 reset state", {dq_oe, data_vld, sync_mode, wrap_mode}, 32'h1);
        chk(wrap_mode == 1'b1 && sync_mode == 1'b0, "R10 mode defaults",
            {wrap_mode, sync_mode}, 32'h2);
    endtask

    task automatic t_no_sync_load();
        bit seen = 1'b0;
        do_load(18'h00040, 1'b1);
        for (int i = 0; i < 10; i++) begin
            if (word_vld) seen = 1'b1;
            step();
        end
        chk(!seen, "R10 no burst while sync off", 32'(seen), 0);
    endtask

    task automatic t_suspend();
        logic [AW-1:0] b = 18'h00101;
        cfg_first_long = 1'b0;
        cfg_next_long  = 1'b0;
        do_load(b, 1'b1);
        for (int n = 0; n < 4; n++) begin
            check_at(b, 1'b1, 3, 1, n, "R7 pre-suspend");
            step();
        end
        // At n=4 word 1 is shown; hold advance for three edges.
        check_at(b, 1'b1, 3, 1, 4, "R7 word1");
        adv_n = 1'b1;
        for (int n = 5; n < 8; n++) begin
            step();
            chk(data_vld && arr_addr == exp_addr(b, 1'b1, 1), "R7 suspend hold",
                {data_vld, 13'd0, arr_addr}, {1'b1, 13'd0, exp_addr(b, 1'b1, 1)});
        end
        adv_n = 1'b0;
        for (int n = 8; n < 11; n++) begin
            step();
            check_at(b, 1'b1, 3, 1, n - 3, "R7 resume");
        end
    endtask

    task automatic t_restart();
        logic [AW-1:0] a = 18'h01230;
        logic [AW-1:0] b = 18'h2FFF1;
        cfg_first_long = 1'b0;
        cfg_next_long  = 1'b0;
        do_load(a, 1'b1);
        for (int n = 0; n < 5; n++) begin
            check_at(a, 1'b1, 3, 1, n, "R12 first burst");
            step();
        end
        do_load(b, 1'b1);
        for (int n = 0; n < 9; n++) begin
            check_at(b, 1'b1, 3, 1, n, "R12 restarted burst");
            step();
        end
    endtask

    task automatic t_write_load();
        do_load(18'h3C3C3, 1'b0);
        chk(waddr_stb && waddr == 18'h3C3C3, "R2 write address",
            {waddr_stb, 13'd0, waddr}, {1'b1, 13'd0, 18'h3C3C3});
        chk(!word_vld, "R2 no read burst", 32'(word_vld), 0);
        step();
        chk(!waddr_stb && !word_vld, "R2 strobe one cycle", {waddr_stb, word_vld}, 0);
    endtask

    task automatic t_out_gate();
        oe_n = 1'b0; od_n = 1'b1; step();
        chk(dq_oe, "R8 drive on", 32'(dq_oe), 1);
        od_n = 1'b0; step();
        chk(!dq_oe, "R9 disable overrides enable", 32'(dq_oe), 0);
        od_n = 1'b1; step();
        chk(dq_oe, "R9 drive back", 32'(dq_oe), 1);
        oe_n = 1'b1; step();
        chk(!dq_oe, "R8 drive off", 32'(dq_oe), 0);
        oe_n = 1'b0; step();
    endtask

    task automatic t_reset_mid();
        pulse_wrap();
        chk(!wrap_mode, "R10 wrap toggled before reset", 32'(wrap_mode), 0);
        cfg_first_long = 1'b0;
        do_load(18'h00200, 1'b1);
        rst_n = 1'b0; step();
        chk(!dq_oe && !word_vld && !data_vld && !sync_mode && wrap_mode,
            "R11 reset mid-burst", {dq_oe, word_vld, data_vld, sync_mode, wrap_mode}, 32'h1);
        rst_n = 1'b1; step();
    endtask

    initial begin
        rst_n = 1'b0; ce_n = 1'b0; ld_n = 1'b1; wr_rd = 1'b1; adv_n = 1'b0;
        oe_n = 1'b0; od_n = 1'b1; addr_in = '0; tog_wrap = 1'b0; tog_sync = 1'b0;
        cfg_first_long = 1'b0; cfg_next_long = 1'b0;
        repeat (3) step();
        t_reset_state();
        rst_n = 1'b1; step();
        t_no_sync_load();
        pulse_sync();
        chk(sync_mode, "R10 sync toggled on", 32'(sync_mode), 1);
        step();
        run_burst(18'h00102, 1'b1, 1'b0, 1'b0, "R4 wrap 3/1");
        run_burst(18'h2A5F3, 1'b1, 1'b1, 1'b1, "R4 wrap 4/2");
        pulse_wrap();
        chk(!wrap_mode, "R10 wrap toggled off", 32'(wrap_mode), 0);
        run_burst(18'h0FFFE, 1'b0, 1'b0, 1'b1, "R5 linear 3/2");
        run_burst(18'h3FFFD, 1'b0, 1'b1, 1'b0, "R5 linear top carry 4/1");
        pulse_wrap();
        t_suspend();
        t_restart();
        t_write_load();
        t_out_gate();
        t_reset_mid();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule